// File: doc/BRIEF.md
# Serial Switch Register Access Master

This block lets on-chip logic read and write the configuration registers and statistics counters of an external Ethernet switch. The link has three wires: a chip-select, a serial clock and one bidirectional data line. The caller places one request on a simple parallel interface. A request carries the operation, a table select, an address and, for a write, 16 bits of data. The block then runs the whole serial exchange on its own. Every serial phase is timed in system clock cycles, and two parameters set the phase lengths.

A write is a single 27-bit frame sent with chip-select high. A read has two legs. First the block sends a 46-bit command with chip-select low. It then releases the data line and issues two idle clocks. After that it clocks in 32 bits from the switch. The configuration table holds 16-bit registers, but the switch returns two of them in each read. The block keeps only the half that the address parity selects. When a read completes, `done_o` pulses for one cycle and `rdata_o` holds the result.

Top module: `sw_serial_master`

## Requirements
- R1: While idle or in reset, `busy_o` and `done_o` are 0 and every serial output is 0: `ser_ctl_oe_o`, `ser_dat_oe_o`, `ser_cs_o`, `ser_clk_o` and `ser_dat_o`.
- R2: A request is taken only in a cycle where `busy_o` is 0. A request presented while busy changes neither the serial waveform nor the result.
- R3: A read command is 46 bits sent most significant first: 32 ones, then 0,1,1,0, then the table bit, then 0,0, then address bits [6:0]. Chip-select stays 0 for the whole read.
- R4: A write frame is 27 bits sent most significant first: 1,0,1, then address [7:0], then data [15:0]. Chip-select is 1 from one edge time before the first bit until the end of the tail phase after the last bit.
- R5: Each bit slot lasts EDGE_CYC cycles with the clock low and data 0, then SETUP_CYC cycles with the clock low and the bit driven, then EDGE_CYC cycles with the clock high and the bit held.
- R6: After the read command's tail, the data enable is 0 for one edge time. Two extra clocks follow, then one edge time with the clock low, and only then do the read bits start.
- R7: Each read bit is sampled in the last cycle before its rising clock edge. The first bit sampled becomes bit 31 of the word.
- R8: After the last bit of a frame, the clock stays low for one edge time. Two extra clocks follow, each high for one edge time and then low for one edge time. Then all drivers are released for one edge time before completion.
- R9: For table 0, an odd address returns word bits [31:16] and an even address returns bits [15:0], zero-extended. For table 1, all 32 bits are returned.
- R10: `busy_o` is 1 from the cycle after acceptance until completion. `done_o` is then 1 for exactly one cycle, with `busy_o` 0 and `rdata_o` valid.
- R11: The data enable is 1 during the command and write bits and 0 during turnaround and read bits. It is only ever 1 while the clock and chip-select drivers are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_table_i | input | 1 | 0 = configuration registers, 1 = counters (reads only) |
| req_addr_i | input | ADDR_W | Register address; reads use the low RD_ADDR_W bits |
| req_wdata_i | input | DATA_W | Write data |
| busy_o | output | 1 | Exchange in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | WORD_W | Read result, valid with done |
| ser_cs_o | output | 1 | Serial chip-select |
| ser_clk_o | output | 1 | Serial clock |
| ser_ctl_oe_o | output | 1 | Driver enable for chip-select and clock |
| ser_dat_o | output | 1 | Serial data out |
| ser_dat_oe_o | output | 1 | Data line driver enable |
| ser_dat_i | input | 1 | Serial data in |

## Verification
Some rules hold on every cycle, and embedded properties check them continuously. The data enable is only ever on while the control drivers are on. Chip-select is only ever high while the data line is driven. Data is stable across every rising clock edge. The done pulse never lasts more than one cycle. A released bus is never clocked. No phase ends early, and no sample is taken once the bit count is spent. Other behaviour depends on whole sequences, and only the bench's scenarios show it. This covers the exact bit order of each frame, the turnaround and extra-clock sequence, the choice of register half by address parity, and the fact that a request raised while busy has no effect.

// File: rtl/swreg_pkg.sv
package swreg_pkg;

   // Phases of one serial exchange
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_PREP,
      ST_CSEL,
      ST_BLO,
      ST_BSU,
      ST_BHI,
      ST_TAIL,
      ST_TURN,
      ST_XHI,
      ST_XLO,
      ST_REL
   } sw_state_e;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/swreg_timer.sv
module swreg_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] dur_i,
   output logic             expired_o
);

   if (CNT_W < 1) begin : g_bad_w
      $error("swreg_timer: CNT_W must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= dur_i - CNT_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign expired_o = (cnt_q == '0);

   // R5
   phase_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_i && (dur_i > CNT_W'(1))) |=> !expired_o);

endmodule

// File: rtl/swreg_shifter.sv
module swreg_shifter #(
   parameter int unsigned FRAME_W = 46,
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned CNT_W   = 6
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               load_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic [CNT_W-1:0]   len_i,
   input  logic               adv_i,
   input  logic               smp_i,
   input  logic               din_i,
   output logic               msb_o,
   output logic               last_o,
   output logic [WORD_W-1:0]  word_o
);

   if (WORD_W < 2) begin : g_bad_word
      $error("swreg_shifter: WORD_W must be at least 2");
   end

   logic [FRAME_W-1:0] frame_q;
   logic [CNT_W-1:0]   left_q;
   logic [WORD_W-1:0]  word_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         frame_q <= '0;
         left_q  <= '0;
         word_q  <= '0;
      end else if (load_i) begin
         frame_q <= frame_i;
         left_q  <= len_i;
         word_q  <= '0;
      end else begin
         if (adv_i) begin
            frame_q <= frame_q << 1;
            left_q  <= left_q - CNT_W'(1);
         end
         if (smp_i) begin
            word_q <= {word_q[WORD_W-2:0], din_i};
         end
      end
   end

   assign msb_o  = frame_q[FRAME_W-1];
   assign last_o = (left_q == CNT_W'(1));
   assign word_o = word_q;

   // R7
   smp_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      smp_i |-> (left_q != '0));

endmodule

// File: rtl/swreg_rdsel.sv
module swreg_rdsel #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned WORD_W    = 32,
   parameter bit          PAIR_PACK = 1'b1
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic              table_i,
   input  logic              odd_i,
   output logic [WORD_W-1:0] rdata_o
);

   if (PAIR_PACK) begin : g_pair
      if (WORD_W < 2 * DATA_W) begin : g_bad_pack
         $error("swreg_rdsel: WORD_W must hold two DATA_W registers");
      end
      always_comb begin
         if (table_i) begin
            rdata_o = word_i;
         end else if (odd_i) begin
            rdata_o = WORD_W'(word_i[2*DATA_W-1 -: DATA_W]);
         end else begin
            rdata_o = WORD_W'(word_i[DATA_W-1:0]);
         end
      end
   end else begin : g_flat
      assign rdata_o = word_i;
   end

endmodule

// File: rtl/sw_serial_master.sv
module sw_serial_master
   import swreg_pkg::*;
#(
   parameter int unsigned EDGE_CYC     = 600,
   parameter int unsigned SETUP_CYC    = 200,
   parameter int unsigned ADDR_W       = 8,
   parameter int unsigned RD_ADDR_W    = 7,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned WORD_W       = 32,
   parameter int unsigned PREAMBLE_LEN = 32,
   parameter int unsigned XTRA_CLKS    = 2,
   parameter bit          PAIR_PACK    = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic              req_table_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [WORD_W-1:0] rdata_o,
   output logic              ser_cs_o,
   output logic              ser_clk_o,
   output logic              ser_ctl_oe_o,
   output logic              ser_dat_o,
   output logic              ser_dat_oe_o,
   input  logic              ser_dat_i
);

   localparam int unsigned RD_LEN  = PREAMBLE_LEN + 7 + RD_ADDR_W;
   localparam int unsigned WR_LEN  = 3 + ADDR_W + DATA_W;
   localparam int unsigned FRAME_W = umax(RD_LEN, WR_LEN);
   localparam int unsigned BIT_W   = $clog2(umax(FRAME_W, WORD_W) + 1);
   localparam int unsigned TMR_W   = $clog2(umax(EDGE_CYC, SETUP_CYC) + 1);
   localparam int unsigned XC_W    = $clog2(XTRA_CLKS + 1);
   localparam logic [TMR_W-1:0] EDGE_T  = TMR_W'(EDGE_CYC);
   localparam logic [TMR_W-1:0] SETUP_T = TMR_W'(SETUP_CYC);
   localparam logic [XC_W-1:0]  XC_LAST = XC_W'(XTRA_CLKS - 1);

   if (EDGE_CYC < 1 || SETUP_CYC < 1) begin : g_bad_time
      $error("sw_serial_master: phase lengths must be at least one cycle");
   end
   if (RD_ADDR_W > ADDR_W || RD_ADDR_W < 1) begin : g_bad_addr
      $error("sw_serial_master: RD_ADDR_W must lie in 1..ADDR_W");
   end
   if (XTRA_CLKS < 1) begin : g_bad_xtra
      $error("sw_serial_master: XTRA_CLKS must be at least 1");
   end

   sw_state_e         st_q, st_d;
   logic              leg_q, leg_d;
   logic [XC_W-1:0]   xc_q, xc_d;
   logic              op_wr_q, op_tbl_q, op_odd_q;
   logic              done_q;
   logic [WORD_W-1:0] rdata_q;

   logic              tmr_load, tmr_exp;
   logic [TMR_W-1:0]  tmr_dur;
   logic              sh_load, sh_adv, sh_smp, sh_msb, sh_last;
   logic [FRAME_W-1:0] sh_frame;
   logic [BIT_W-1:0]  sh_len;
   logic [WORD_W-1:0] sh_word, sel_word;
   logic              fin;

   // Command framing from the request fields
   logic [RD_LEN-1:0]  rd_frm;
   logic [WR_LEN-1:0]  wr_frm;
   logic [FRAME_W-1:0] cmd_frm;

   assign rd_frm  = {{PREAMBLE_LEN{1'b1}}, 4'b0110, req_table_i, 2'b00,
                     req_addr_i[RD_ADDR_W-1:0]};
   assign wr_frm  = {3'b101, req_addr_i, req_wdata_i};
   assign cmd_frm = req_write_i ? (FRAME_W'(wr_frm) << (FRAME_W - WR_LEN))
                                : (FRAME_W'(rd_frm) << (FRAME_W - RD_LEN));

   swreg_timer #(.CNT_W(TMR_W)) i_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (tmr_load),
      .dur_i     (tmr_dur),
      .expired_o (tmr_exp)
   );

   swreg_shifter #(.FRAME_W(FRAME_W), .WORD_W(WORD_W), .CNT_W(BIT_W)) i_shift (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (sh_load),
      .frame_i (sh_frame),
      .len_i   (sh_len),
      .adv_i   (sh_adv),
      .smp_i   (sh_smp),
      .din_i   (ser_dat_i),
      .msb_o   (sh_msb),
      .last_o  (sh_last),
      .word_o  (sh_word)
   );

   swreg_rdsel #(.DATA_W(DATA_W), .WORD_W(WORD_W), .PAIR_PACK(PAIR_PACK)) i_rdsel (
      .word_i  (sh_word),
      .table_i (op_tbl_q),
      .odd_i   (op_odd_q),
      .rdata_o (sel_word)
   );

   // Phase sequencing
   always_comb begin
      st_d     = st_q;
      leg_d    = leg_q;
      xc_d     = xc_q;
      tmr_load = 1'b0;
      tmr_dur  = EDGE_T;
      sh_load  = 1'b0;
      sh_frame = cmd_frm;
      sh_len   = req_write_i ? BIT_W'(WR_LEN) : BIT_W'(RD_LEN);
      sh_adv   = 1'b0;
      sh_smp   = 1'b0;
      fin      = 1'b0;
      if (st_q == ST_IDLE) begin
         if (req_valid_i) begin
            st_d     = ST_PREP;
            leg_d    = 1'b0;
            tmr_load = 1'b1;
            sh_load  = 1'b1;
         end
      end else if (tmr_exp) begin
         tmr_load = 1'b1;
         case (st_q)
            ST_PREP: st_d = ST_CSEL;
            ST_CSEL: st_d = ST_BLO;
            ST_BLO: begin
               st_d    = ST_BSU;
               tmr_dur = SETUP_T;
            end
            ST_BSU: begin
               st_d   = ST_BHI;
               sh_smp = leg_q;
            end
            ST_BHI: begin
               sh_adv = 1'b1;
               st_d   = sh_last ? ST_TAIL : ST_BLO;
            end
            ST_TAIL: begin
               xc_d = '0;
               st_d = (!leg_q && !op_wr_q) ? ST_TURN : ST_XHI;
            end
            ST_TURN: st_d = ST_XHI;
            ST_XHI:  st_d = ST_XLO;
            ST_XLO: begin
               if (xc_q == XC_LAST) begin
                  if (!leg_q && !op_wr_q) begin
                     leg_d    = 1'b1;
                     st_d     = ST_CSEL;
                     sh_load  = 1'b1;
                     sh_frame = '0;
                     sh_len   = BIT_W'(WORD_W);
                  end else begin
                     st_d = ST_REL;
                  end
               end else begin
                  xc_d = xc_q + XC_W'(1);
                  st_d = ST_XHI;
               end
            end
            ST_REL: begin
               tmr_load = 1'b0;
               fin      = 1'b1;
               st_d     = ST_IDLE;
            end
            default: begin
               tmr_load = 1'b0;
               st_d     = ST_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q     <= ST_IDLE;
         leg_q    <= 1'b0;
         xc_q     <= '0;
         op_wr_q  <= 1'b0;
         op_tbl_q <= 1'b0;
         op_odd_q <= 1'b0;
         done_q   <= 1'b0;
         rdata_q  <= '0;
      end else begin
         st_q   <= st_d;
         leg_q  <= leg_d;
         xc_q   <= xc_d;
         done_q <= fin;
         if (st_q == ST_IDLE && req_valid_i) begin
            op_wr_q  <= req_write_i;
            op_tbl_q <= req_table_i;
            op_odd_q <= req_addr_i[0];
         end
         if (fin && !op_wr_q) begin
            rdata_q <= sel_word;
         end
      end
   end

   // Pin decode
   logic in_slot, in_xtra, cs_span;

   assign in_slot = (st_q == ST_BSU) || (st_q == ST_BHI);
   assign in_xtra = (st_q == ST_TURN) || (st_q == ST_XHI) || (st_q == ST_XLO);
   assign cs_span = (st_q == ST_CSEL) || (st_q == ST_BLO) || in_slot ||
                    (st_q == ST_TAIL);

   assign busy_o       = (st_q != ST_IDLE);
   assign done_o       = done_q;
   assign rdata_o      = rdata_q;
   assign ser_ctl_oe_o = (st_q != ST_IDLE) && (st_q != ST_REL);
   assign ser_dat_oe_o = ser_ctl_oe_o && !leg_q && (op_wr_q || !in_xtra);
   assign ser_cs_o     = op_wr_q && cs_span;
   assign ser_clk_o    = (st_q == ST_BHI) || (st_q == ST_XHI);
   assign ser_dat_o    = !leg_q && in_slot && sh_msb;

   // R11
   dat_oe_ctl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ser_dat_oe_o |-> ser_ctl_oe_o);

   // R4
   cs_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ser_cs_o |-> ser_dat_oe_o);

   // R5
   setup_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(ser_clk_o) && ser_dat_oe_o) |-> $stable(ser_dat_o));

   // R10
   done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   // R1
   idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ser_ctl_oe_o |-> (!ser_clk_o && !ser_cs_o));

endmodule

// File: tb/test_sw_serial_master.sv
`timescale 1ns/1ps
module test_sw_serial_master;

   localparam int EDGE  = 3;
   localparam int SETUP = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic        req_table = 1'b0;
   logic [7:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        busy, done;
   logic [31:0] rdata;
   logic        s_cs, s_clk, s_ctl_oe, s_dat, s_dat_oe;
   logic        s_din = 1'b0;

   always #2.5 clk = ~clk;

   sw_serial_master #(.EDGE_CYC(EDGE), .SETUP_CYC(SETUP)) i_sw_serial_master (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .req_valid_i  (req_valid),
      .req_write_i  (req_write),
      .req_table_i  (req_table),
      .req_addr_i   (req_addr),
      .req_wdata_i  (req_wdata),
      .busy_o       (busy),
      .done_o       (done),
      .rdata_o      (rdata),
      .ser_cs_o     (s_cs),
      .ser_clk_o    (s_clk),
      .ser_ctl_oe_o (s_ctl_oe),
      .ser_dat_o    (s_dat),
      .ser_dat_oe_o (s_dat_oe),
      .ser_dat_i    (s_din)
   );

   int    checks = 0;
   int    errors = 0;
   bit    finished = 1'b0;
   string extra_tag = "";

   // entry: busy, done, ctl_oe, cs, clk, dat_oe, dat, din
   logic [7:0]  exp_q[$];
   string       tag_q[$];
   logic [32:0] rd_q[$];

   function automatic logic [7:0] ent(input logic b, input logic dn, input logic co,
                                      input logic cs, input logic ck, input logic doe,
                                      input logic d, input logic di);
      return {b, dn, co, cs, ck, doe, d, di};
   endfunction

   task automatic pushn(input int n, input logic [7:0] e, input string t);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(e);
         tag_q.push_back(t);
      end
   endtask

   task automatic push_bit(input logic cs, input logic doe, input logic b,
                           input logic di, input string t);
      pushn(EDGE,  ent(1, 0, 1, cs, 0, doe, 0, di), "R5");
      pushn(SETUP, ent(1, 0, 1, cs, 0, doe, b, di), t);
      pushn(EDGE,  ent(1, 0, 1, cs, 1, doe, b, di), t);
   endtask

   task automatic push_tail(input logic cs, input logic doe_t, input logic doe_x,
                            input logic turn, input string t);
      pushn(EDGE, ent(1, 0, 1, cs, 0, doe_t, 0, 0), "R8");
      if (turn) pushn(EDGE, ent(1, 0, 1, 0, 0, 0, 0, 0), "R6");
      for (int k = 0; k < 2; k++) begin
         pushn(EDGE, ent(1, 0, 1, 0, 1, doe_x, 0, 0), t);
         pushn(EDGE, ent(1, 0, 1, 0, 0, doe_x, 0, 0), t);
      end
   endtask

   task automatic push_end(input logic [32:0] rd, input string t);
      pushn(EDGE, ent(1, 0, 0, 0, 0, 0, 0, 0), "R8");
      pushn(1, ent(0, 1, 0, 0, 0, 0, 0, 0), t);
      rd_q.push_back(rd);
   endtask

   task automatic model_write(input logic [7:0] a, input logic [15:0] d);
      logic bits[$];
      bits = {1'b1, 1'b0, 1'b1};
      for (int i = 7; i >= 0; i--) bits.push_back(a[i]);
      for (int i = 15; i >= 0; i--) bits.push_back(d[i]);
      pushn(EDGE, ent(1, 0, 1, 0, 0, 1, 0, 0), "R11");
      pushn(EDGE, ent(1, 0, 1, 1, 0, 1, 0, 0), "R4");
      foreach (bits[i]) push_bit(1, 1, bits[i], 0, "R4");
      push_tail(1, 1, 1, 0, "R8");
      push_end(33'h0, "R10");
   endtask

   task automatic model_read(input logic t, input logic [7:0] a, input logic [31:0] w);
      logic bits[$];
      logic [31:0] res;
      for (int i = 0; i < 32; i++) bits.push_back(1'b1);
      bits.push_back(1'b0); bits.push_back(1'b1); bits.push_back(1'b1); bits.push_back(1'b0);
      bits.push_back(t); bits.push_back(1'b0); bits.push_back(1'b0);
      for (int i = 6; i >= 0; i--) bits.push_back(a[i]);
      pushn(EDGE, ent(1, 0, 1, 0, 0, 1, 0, 0), "R11");
      pushn(EDGE, ent(1, 0, 1, 0, 0, 1, 0, 0), "R3");
      foreach (bits[i]) push_bit(0, 1, bits[i], 0, "R3");
      push_tail(0, 1, 0, 1, "R6");
      pushn(EDGE, ent(1, 0, 1, 0, 0, 0, 0, 0), "R6");
      for (int i = 31; i >= 0; i--) push_bit(0, 0, 0, w[i], "R7");
      push_tail(0, 0, 0, 0, "R8");
      if (t) res = w;
      else if (a[0]) res = {16'h0, w[31:16]};
      else res = {16'h0, w[15:0]};
      push_end({1'b1, res}, "R9");
   endtask

   task automatic tick();
      logic [7:0] e, got;
      string t;
      logic [32:0] rd;
      @(negedge clk);
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
      end else begin
         e = ent(0, 0, 0, 0, 0, 0, 0, 0);
         t = "R1";
      end
      got = {busy, done, s_ctl_oe, s_cs, s_clk, s_dat_oe, s_dat, e[0]};
      checks++;
      if (got[7:1] !== e[7:1]) begin
         errors++;
         $display("FAIL %s%s pins {busy,done,ctl,cs,clk,doe,dat} got %b exp %b at %0t",
                  t, extra_tag, got[7:1], e[7:1], $time);
      end
      if (e[6] && rd_q.size() > 0) begin
         rd = rd_q.pop_front();
         if (rd[32]) begin
            checks++;
            if (rdata !== rd[31:0]) begin
               errors++;
               $display("FAIL R9 rdata got %h exp %h", rdata, rd[31:0]);
            end
         end
      end
      s_din = e[0];
   endtask

   task automatic drain();
      int guard = 0;
      while (exp_q.size() > 0 && guard < 20000) begin
         tick();
         guard++;
      end
   endtask

   task automatic issue(input logic wr, input logic t, input logic [7:0] a,
                        input logic [15:0] d, input logic [31:0] w);
      drain();
      req_valid = 1'b1; req_write = wr; req_table = t; req_addr = a; req_wdata = d;
      if (wr) model_write(a, d);
      else model_read(t, a, w);
      tick();
      req_valid = 1'b0;
   endtask

   initial begin
      // R1: reset state
      for (int i = 0; i < 4; i++) tick();
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) tick();
      // R4 writes
      issue(1'b1, 1'b0, 8'h11, 16'hFF30, 32'h0);
      issue(1'b1, 1'b1, 8'hA5, 16'h5AC3, 32'h0);
      // R9 table 0 odd / even, table 1 full
      issue(1'b0, 1'b0, 8'h13, 16'h0, 32'hDEADBEEF);
      issue(1'b0, 1'b0, 8'h08, 16'h0, 32'h12345678);
      issue(1'b0, 1'b1, 8'h3C, 16'h0, 32'hCAFEF00D);
      issue(1'b0, 1'b1, 8'h00, 16'h0, 32'h80000001);
      // R2: request while busy is ignored
      issue(1'b0, 1'b0, 8'h55, 16'h0, 32'hA5A55A5A);
      extra_tag = " R2";
      for (int i = 0; i < 20; i++) tick();
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'hFF; req_wdata = 16'hFFFF;
      for (int i = 0; i < 3; i++) tick();
      req_valid = 1'b0;
      drain();
      for (int i = 0; i < 10; i++) tick();
      extra_tag = "";
      // back-to-back write then read
      issue(1'b1, 1'b0, 8'h7E, 16'h0001, 32'h0);
      issue(1'b0, 1'b0, 8'h7F, 16'h0, 32'h0F0FF0F0);
      drain();
      for (int i = 0; i < 5; i++) tick();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired got running exp finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule